// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a virtual address that missed in the translation cache. It walks a two-level page table held in memory. A 32-bit virtual address is split into three fields: bits [31:22] index the first-level (super) table, bits [21:12] index the second-level table, and bits [11:0] are the offset inside a 4 KB page. The walker issues at most two dependent reads through a simple request/response port. It then reports either a physical page number with its access rights, or a page fault.

The super table starts at the address held in the table base register. This register is sampled when a walk is accepted, so software can reload it on a process switch. A super entry whose valid bit is clear means no second-level table exists. In that case the walk ends at once with a fault and no second read is made. When a walk completes, a one-cycle `done` pulse presents the result and the virtual page number. The translation cache captures them on that pulse and fills an entry from them.

Every table entry is 32 bits wide:
- bit 0 is valid.
- bit 1 is read permission.
- bit 2 is write permission.
- bit 3 is execute permission.
- bits [11:4] are unused.
- bits [31:12] are a physical page number.

In a super entry, that page number, shifted left by 12, is the base address of the second-level table.

Top module: `ptw_walker`

## Requirements
- R1: While reset is high, and in the first cycle after it, `busy`, `done`, `mem_req_valid`, `fault`, `fault_lvl`, `res_ppn` and `res_rights` are all 0.
- R2: The first read goes to `ptbr + 4*vaddr[31:22]`, using the values sampled at acceptance. `mem_req_valid` and `mem_req_addr` stay unchanged until a cycle with `mem_req_ready` high.
- R3: When the super entry has bit 0 set, the second read goes to `{entry[31:12], 12'h000} + 4*vaddr[21:12]`.
- R4: When the super entry has bit 0 clear, the walk ends with `fault`=1 and `fault_lvl`=0. No second request is made, and `res_ppn` and `res_rights` are 0.
- R5: When the second-level entry has bit 0 clear, the walk ends with `fault`=1 and `fault_lvl`=1. `res_ppn` and `res_rights` are 0.
- R6: When the second-level entry has bit 0 set, the walk ends with `fault`=0, `res_ppn` = entry[31:12] and `res_rights` = entry[3:1] (execute, write, read). `res_vpn` equals `vaddr[31:12]` in every case.
- R7: `done` is high for exactly one cycle per walk. The result outputs then hold until the next walk is accepted.
- R8: `req_valid` is ignored while `busy` is high. Changes to `req_vaddr` or `ptbr` after acceptance do not affect the walk.
- R9: The walker waits any number of cycles for `mem_req_ready` and for `mem_rsp_valid`. The result does not depend on these latencies.
- R10: Bringing reset high in the middle of a walk returns the block to idle, with no request outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a walk (accepted only when idle) |
| req_vaddr | input | 32 | Virtual address to translate |
| ptbr | input | 32 | Super-table base address |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 32 | Table entry read from memory |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended in a page fault |
| fault_lvl | output | 1 | Fault level: 0 super entry, 1 second-level entry |
| res_ppn | output | 20 | Physical page number |
| res_rights | output | 3 | Access rights {execute, write, read} |
| res_vpn | output | 20 | Virtual page number of the walk, used to fill the cache |

## Verification
The hardest case to reach is a change of inputs while a walk is stalled in the middle. A new request, a new base register value or a new address must not leak into a read that is already pending. The bench reaches this case by holding `mem_req_ready` and `mem_rsp_valid` low for several cycles. During those cycles it raises `req_valid` and drives the inverse of the accepted address and base. It then checks that both read addresses and the result still follow the original values. The bench also stalls a walk before the memory grant and pulls reset there, to reach the abandoned-walk case.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W      = 32;
    localparam int PA_W      = 32;
    localparam int PTE_W     = 32;
    localparam int OFF_W     = 12;
    localparam int L1_IDX_W  = 10;
    localparam int L2_IDX_W  = 10;
    localparam int ENT_LG    = 2;                 // log2 of entry size in bytes
    localparam int PPN_W     = PA_W - OFF_W;
    localparam int VPN_W     = VA_W - OFF_W;
    localparam int RIGHTS_W  = 3;
    localparam int RSVD_W    = OFF_W - RIGHTS_W - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_DONE
    } walk_state_e;

    typedef struct packed {
        logic [PPN_W-1:0]  ppn;
        logic [RSVD_W-1:0] rsvd;
        logic              x;
        logic              w;
        logic              r;
        logic              valid;
    } pte_t;

    function automatic logic [PA_W-1:0] page_base(input logic [PPN_W-1:0] ppn);
        return {ppn, {OFF_W{1'b0}}};
    endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int IDX_W  = 10,
    parameter int ADDR_W = 32,
    parameter int SH     = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    localparam int PAD_W = ADDR_W - IDX_W - SH;

    logic [ADDR_W-1:0] scaled;

    always_comb begin
        scaled = {{PAD_W{1'b0}}, idx, {SH{1'b0}}};
        addr   = base + scaled;
    end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        mem_req_ready,
    input  logic        mem_rsp_valid,
    input  logic        l1_ok,
    output walk_state_e state,
    output logic        accept,
    output logic        l1_rsp,
    output logic        l2_rsp
);
    walk_state_e nxt;

    always_comb begin
        accept = (state == ST_IDLE) && req_valid;
        l1_rsp = (state == ST_L1_WAIT) && mem_rsp_valid;
        l2_rsp = (state == ST_L2_WAIT) && mem_rsp_valid;
        nxt    = state;
        unique case (state)
            ST_IDLE:    if (req_valid)     nxt = ST_L1_REQ;
            ST_L1_REQ:  if (mem_req_ready) nxt = ST_L1_WAIT;
            ST_L1_WAIT: if (mem_rsp_valid) nxt = l1_ok ? ST_L2_REQ : ST_DONE;
            ST_L2_REQ:  if (mem_req_ready) nxt = ST_L2_WAIT;
            ST_L2_WAIT: if (mem_rsp_valid) nxt = ST_DONE;
            ST_DONE:                       nxt = ST_IDLE;
            default:                       nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // R4: an invalid super entry ends the walk without a second-level phase
    a_r4_skip_l2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_L1_WAIT && mem_rsp_valid && !l1_ok) |=> (state == ST_DONE));

    // R9: a wait state is left only on a response
    a_r9_wait_rsp: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_L1_WAIT || state == ST_L2_WAIT) && !mem_rsp_valid) |=> $stable(state));
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [VA_W-1:0]     req_vaddr,
    input  logic [PA_W-1:0]     ptbr,
    output logic                busy,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [PA_W-1:0]     mem_req_addr,
    input  logic                mem_rsp_valid,
    input  logic [PTE_W-1:0]    mem_rsp_data,
    output logic                done,
    output logic                fault,
    output logic                fault_lvl,
    output logic [PPN_W-1:0]    res_ppn,
    output logic [RIGHTS_W-1:0] res_rights,
    output logic [VPN_W-1:0]    res_vpn
);
    localparam int L1_LSB = VA_W - L1_IDX_W;
    localparam int L2_LSB = OFF_W;

    walk_state_e       state;
    logic              accept, l1_rsp, l2_rsp;
    logic [VA_W-1:0]   va_q;
    logic [PA_W-1:0]   base_q;
    logic [PA_W-1:0]   addr_l1, addr_l2;
    pte_t              rsp_pte;

    assign rsp_pte = pte_t'(mem_rsp_data);

    ptw_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .l1_ok         (rsp_pte.valid),
        .state         (state),
        .accept        (accept),
        .l1_rsp        (l1_rsp),
        .l2_rsp        (l2_rsp)
    );

    ptw_addr_gen #(.IDX_W(L1_IDX_W), .ADDR_W(PA_W), .SH(ENT_LG)) u_ag_l1 (
        .base (base_q),
        .idx  (va_q[VA_W-1:L1_LSB]),
        .addr (addr_l1)
    );

    ptw_addr_gen #(.IDX_W(L2_IDX_W), .ADDR_W(PA_W), .SH(ENT_LG)) u_ag_l2 (
        .base (base_q),
        .idx  (va_q[L2_LSB+L2_IDX_W-1:L2_LSB]),
        .addr (addr_l2)
    );

    always_comb begin
        busy          = (state != ST_IDLE);
        done          = (state == ST_DONE);
        mem_req_valid = (state == ST_L1_REQ) || (state == ST_L2_REQ);
        mem_req_addr  = (state == ST_L2_REQ) ? addr_l2 : addr_l1;
    end

    // walk context: sampled address, and base that becomes the second-level base
    always_ff @(posedge clk) begin
        if (rst) begin
            va_q   <= '0;
            base_q <= '0;
        end else if (accept) begin
            va_q   <= req_vaddr;
            base_q <= ptbr;
        end else if (l1_rsp && rsp_pte.valid) begin
            base_q <= page_base(rsp_pte.ppn);
        end
    end

    // result registers
    always_ff @(posedge clk) begin
        if (rst) begin
            fault      <= 1'b0;
            fault_lvl  <= 1'b0;
            res_ppn    <= '0;
            res_rights <= '0;
            res_vpn    <= '0;
        end else if (accept) begin
            fault      <= 1'b0;
            fault_lvl  <= 1'b0;
            res_ppn    <= '0;
            res_rights <= '0;
            res_vpn    <= req_vaddr[VA_W-1:OFF_W];
        end else if (l1_rsp && !rsp_pte.valid) begin
            fault      <= 1'b1;
            fault_lvl  <= 1'b0;
        end else if (l2_rsp) begin
            if (rsp_pte.valid) begin
                res_ppn    <= rsp_pte.ppn;
                res_rights <= {rsp_pte.x, rsp_pte.w, rsp_pte.r};
            end else begin
                fault      <= 1'b1;
                fault_lvl  <= 1'b1;
            end
        end
    end

    // R2: a request not yet taken keeps its address
    a_r2_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R7: completion is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: results hold while idle without a new request
    a_r7_result_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !req_valid) |=> $stable({fault, fault_lvl, res_ppn, res_rights, res_vpn}));

    // R8: no memory traffic while idle
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req_valid);

    // R4 / R5: a fault carries no page number or rights
    a_r5_fault_clean: assert property (@(posedge clk) disable iff (rst)
        (done && fault) |-> (res_ppn == '0 && res_rights == '0));
endmodule

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
    import ptw_pkg::*;

    localparam int CLK_P = 10;
    localparam int NV    = 6;

    typedef struct packed {
        logic [31:0] va;
        logic [31:0] pt;
        logic [7:0]  lat;
        logic        flt;
        logic        lvl;
        logic [19:0] ppn;
        logic [2:0]  rt;
        logic [1:0]  nreq;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{32'h0040_3ABC, 32'h0001_0000, 8'd2, 1'b0, 1'b0, 20'h000AB, 3'b101, 2'd2},
        '{32'hFFC0_0000, 32'h0001_0000, 8'd1, 1'b1, 1'b0, 20'h00000, 3'b000, 2'd1},
        '{32'h0040_4000, 32'h0001_0000, 8'd4, 1'b1, 1'b1, 20'h00000, 3'b000, 2'd2},
        '{32'h0080_1000, 32'h0002_0000, 8'd0, 1'b0, 1'b0, 20'hFFFFF, 3'b001, 2'd2},
        '{32'h0040_3ABC, 32'h0002_0000, 8'd0, 1'b1, 1'b0, 20'h00000, 3'b000, 2'd1},
        '{32'h0040_3FFF, 32'h0001_0000, 8'd3, 1'b0, 1'b0, 20'h000AB, 3'b101, 2'd2}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [31:0] ptbr = '0;
    logic mem_req_ready = 1'b0;
    logic mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic busy, mem_req_valid, done, fault, fault_lvl;
    logic [31:0] mem_req_addr;
    logic [19:0] res_ppn, res_vpn;
    logic [2:0]  res_rights;

    logic [31:0] pmem [logic [31:0]];

    int checks = 0;
    int errors = 0;

    int          w_nreq;
    logic [31:0] w_a1, w_a2;
    logic        w_done, w_unstable;
    logic        c_flt, c_lvl;
    logic [19:0] c_ppn, c_vpn;
    logic [2:0]  c_rt;

    always #(CLK_P/2) clk = ~clk;

    ptw_walker dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .ptbr(ptbr), .busy(busy), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .fault(fault), .fault_lvl(fault_lvl), .res_ppn(res_ppn),
        .res_rights(res_rights), .res_vpn(res_vpn)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return pmem.exists(a) ? pmem[a] : 32'h0;
    endfunction

    // Drives one walk and serves memory with the given stall length.
    task automatic run_walk(input logic [31:0] va, input logic [31:0] pt, input int lat);
        logic [31:0] cur;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; ptbr = pt;
        @(negedge clk);
        req_valid = 1'b0; req_vaddr = ~va; ptbr = ~pt;   // R8: late changes
        w_nreq = 0; w_done = 1'b0; w_unstable = 1'b0;
        for (int cyc = 0; cyc < 200 && !w_done; cyc++) begin
            if (done) begin
                w_done = 1'b1;
                c_flt = fault; c_lvl = fault_lvl; c_ppn = res_ppn;
                c_rt = res_rights; c_vpn = res_vpn;
            end else if (mem_req_valid) begin
                cur = mem_req_addr;
                if (w_nreq == 0) w_a1 = cur; else w_a2 = cur;
                w_nreq++;
                for (int k = 0; k < lat; k++) begin
                    req_valid = 1'b1;                    // R8: ignored while busy
                    @(negedge clk);
                    if (!mem_req_valid || mem_req_addr !== cur) w_unstable = 1'b1;
                end
                req_valid = 1'b0;
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                for (int k = 0; k < lat; k++) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data = rd(cur);
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_data = 32'hDEAD_BEEF;
            end else begin
                @(negedge clk);
            end
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        pmem[32'h0001_0004] = 32'h0005_0001;   // super entry, table at 0x50000
        pmem[32'h0005_000C] = 32'h000A_B00B;   // valid, rights x=1 w=0 r=1
        pmem[32'h0005_0010] = 32'h0000_0006;   // not resident
        pmem[32'h0002_0008] = 32'h0007_7001;   // super entry, table at 0x77000
        pmem[32'h0007_7004] = 32'hFFFF_F003;   // valid, read only

        repeat (3) @(negedge clk);
        chk("R1 busy in reset", {31'b0, busy}, 32'd0);
        chk("R1 done in reset", {31'b0, done}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 mem_req_valid after reset", {31'b0, mem_req_valid}, 32'd0);
        chk("R1 result after reset", {10'b0, fault, fault_lvl, res_ppn}, 32'd0);
        chk("R1 rights after reset", {29'b0, res_rights}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [31:0] e1, e2;
            logic [19:0] held;
            v = VECS[i];
            run_walk(v.va, v.pt, int'(v.lat));
            e1 = v.pt + {20'b0, v.va[31:22], 2'b00};
            chk("R9 walk completed", {31'b0, w_done}, 32'd1);
            chk("R2 request held while stalled", {31'b0, w_unstable}, 32'd0);
            chk("R2 first read address", w_a1, e1);
            chk("R4 request count", w_nreq, {30'b0, v.nreq});
            if (v.nreq == 2'd2) begin
                e2 = {rd(e1)[31:12], 12'h000} + {20'b0, v.va[21:12], 2'b00};
                chk("R3 second read address", w_a2, e2);
            end
            chk(v.lvl ? "R5 fault flag" : "R4 fault flag", {31'b0, c_flt}, {31'b0, v.flt});
            chk("R5 fault level", {31'b0, c_lvl}, {31'b0, v.lvl});
            chk("R6 physical page", {12'b0, c_ppn}, {12'b0, v.ppn});
            chk("R6 rights", {29'b0, c_rt}, {29'b0, v.rt});
            chk("R6 virtual page for fill", {12'b0, c_vpn}, {12'b0, v.va[31:12]});
            held = res_ppn;
            @(negedge clk);
            chk("R7 done single cycle", {31'b0, done}, 32'd0);
            repeat (2) @(negedge clk);
            chk("R7 result held", {12'b0, res_ppn}, {12'b0, held});
            chk("R7 fault held", {31'b0, fault}, {31'b0, v.flt});
        end

        // R10: reset while a request waits for the memory grant
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 32'h0040_3000; ptbr = 32'h0001_0000;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R10 request pending before reset", {31'b0, mem_req_valid}, 32'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 idle after reset", {31'b0, busy}, 32'd0);
        chk("R10 no request after reset", {31'b0, mem_req_valid}, 32'd0);
        chk("R1 done low after reset", {31'b0, done}, 32'd0);

        run_walk(32'h0040_3000, 32'h0001_0000, 1);
        chk("R10 walk after reset page", {12'b0, c_ppn}, 32'h0000_00AB);
        chk("R10 walk after reset fault", {31'b0, c_flt}, 32'd0);

        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule